// File: doc/BRIEF.md
# Flash Status and Write-Protection Unit

This unit keeps the status byte of a serial NOR flash and decides whether each write-class request may run. A command front-end hands it one strobe per completed, byte-aligned command, together with a 3-bit operation code, the 24-bit target address and, for a status write, the new status byte. The unit answers each program, erase or status-write request with a one-cycle grant or deny pulse. It also shows the busy window of the self-timed cycle that a grant starts.

Protection comes from two sources. The three block-protect bits mark a top-down region of the sixteen 64 KB blocks. A hardware mode, formed by the status-write-disable bit with the write-protect pin low, freezes the status register. The lengths of the self-timed cycles and the power-up write-inhibit window are parameters in system clock cycles. Array contents and the serial link are handled elsewhere.

Top module: `flash_status_guard`

## Requirements
- R1: After reset `status` is 00h. Its layout is bit 7 SRWD, bits 4..2 BP2..BP0, bit 1 WEL and bit 0 WIP. Bits 6 and 5 always read 0.
- R2: Operation codes are 0 write-enable, 1 write-disable, 2 status write, 3 page program, 4 sector erase, 5 block erase, 6 chip erase and 7 unused. Code 0 sets WEL and code 1 clears it. Neither code gives a grant or a deny.
- R3: For codes 2 to 6, `grant` or `deny` pulses for one cycle in the cycle after the strobe. If WEL is 0, the request is denied. A denied request changes no status bit, so WEL stays as it was.
- R4: With BP = 000 nothing is protected. BP = 001 protects addresses from 0F0000h upward, 010 from 0E0000h, 011 from 0C0000h and 100 from 080000h. BP = 101, 110 and 111 protect every address. A page program, sector erase or block erase whose address lies in the protected range is denied.
- R5: A chip erase is granted only when BP is 000.
- R6: When SRWD is 1 and `wp_n` is 0, a status write is denied even if WEL is 1. With `wp_n` at 1 the same request is granted.
- R7: A status write takes bits 7 and 4..2 of `cmd_wdata` into SRWD and BP when its cycle ends. Bits 6, 5, 1 and 0 of the data have no effect.
- R8: A grant sets WIP and `busy` from the cycle of the grant pulse. They stay high for exactly the configured length of that operation: T_WRSR, T_PP, T_SE, T_BE or T_CE cycles. WIP and WEL then clear in the same cycle.
- R9: Any request that arrives while WIP is 1, including codes 0 and 1, is dropped. It gives no pulse and leaves the status unchanged.
- R10: For T_PUW cycles after reset, codes 0 to 6 are ignored. They give no pulse and change no state.
- R11: Code 7 gives no pulse and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, the power-up event |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | One-cycle strobe for a completed command |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | ADDR_W | Target address of program and erase requests |
| cmd_wdata | input | 8 | New status byte for a status write |
| status | output | 8 | Status byte |
| grant | output | 1 | Request accepted, self-timed cycle started |
| deny | output | 1 | Request refused |
| busy | output | 1 | Self-timed cycle in progress |

## Verification
The bench builds the unit with cycle lengths of 3, 5, 7, 9 and 11 clocks and a 20-clock write-inhibit window. These values keep every busy window short enough to count edge by edge. A request can therefore land in the inhibit window, in the middle of a cycle and at the edge where a cycle ends, all in one short run. At these lengths every protect level can be tested on both sides of its lower boundary, and the hardware-protect path can be tested with the pin in both states.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W  = 24,
  parameter int BLK_LSB = 16,
  parameter int BLK_W   = 4,
  parameter int CNT_W   = 32,
  parameter int T_WRSR  = 1500000,
  parameter int T_PP    = 140000,
  parameter int T_SE    = 6000000,
  parameter int T_BE    = 100000000,
  parameter int T_CE    = 800000000,
  parameter int T_PUW   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic [7:0]        status,
  output logic              grant,
  output logic              deny,
  output logic              busy
);

  localparam logic [2:0] OP_WEN  = 3'd0;
  localparam logic [2:0] OP_WDIS = 3'd1;
  localparam logic [2:0] OP_SWR  = 3'd2;
  localparam logic [2:0] OP_PROG = 3'd3;
  localparam logic [2:0] OP_SERS = 3'd4;
  localparam logic [2:0] OP_BERS = 3'd5;
  localparam logic [2:0] OP_CERS = 3'd6;
  localparam int NBLK  = 1 << BLK_W;
  localparam int PUW_W = (T_PUW > 0) ? $clog2(T_PUW + 1) : 1;

  logic             srwd, wel, wip, pend_sr, srwd_nx;
  logic [2:0]       bp, bp_nx;
  logic [CNT_W-1:0] cnt, len;
  logic [PUW_W-1:0] pu_cnt;
  logic [ADDR_W-1:0] prot_lo;
  logic             locked, hw_lock, take, in_prot, ok, is_cyc;
  logic             unused_wdata;

  assign unused_wdata = &{1'b0, cmd_wdata[6:5], cmd_wdata[1:0]};
  assign locked  = pu_cnt != PUW_W'(T_PUW);
  assign hw_lock = srwd & ~wp_n;
  assign take    = cmd_valid & ~locked & ~wip;
  assign is_cyc  = (cmd_op >= OP_SWR) && (cmd_op <= OP_CERS);

  always_comb begin
    prot_lo = '0;
    in_prot = 1'b0;
    if (bp != 3'd0) begin
      if (int'(bp) > BLK_W) begin
        in_prot = 1'b1;
      end else begin
        prot_lo = ADDR_W'(NBLK - (1 << (int'(bp) - 1))) << BLK_LSB;
        in_prot = cmd_addr >= prot_lo;
      end
    end
  end

  always_comb begin
    ok  = 1'b0;
    len = '0;
    case (cmd_op)
      OP_SWR:  begin ok = wel & ~hw_lock;  len = CNT_W'(T_WRSR - 1); end
      OP_PROG: begin ok = wel & ~in_prot;  len = CNT_W'(T_PP - 1);   end
      OP_SERS: begin ok = wel & ~in_prot;  len = CNT_W'(T_SE - 1);   end
      OP_BERS: begin ok = wel & ~in_prot;  len = CNT_W'(T_BE - 1);   end
      OP_CERS: begin ok = wel & (bp == 3'd0); len = CNT_W'(T_CE - 1); end
      default: begin ok = 1'b0; len = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd    <= 1'b0;
      bp      <= 3'd0;
      wel     <= 1'b0;
      wip     <= 1'b0;
      pend_sr <= 1'b0;
      srwd_nx <= 1'b0;
      bp_nx   <= 3'd0;
      cnt     <= '0;
      pu_cnt  <= '0;
      grant   <= 1'b0;
      deny    <= 1'b0;
    end else begin
      grant <= 1'b0;
      deny  <= 1'b0;
      if (locked) pu_cnt <= pu_cnt + 1'b1;
      if (wip) begin
        if (cnt == '0) begin
          wip     <= 1'b0;
          wel     <= 1'b0;
          pend_sr <= 1'b0;
          if (pend_sr) begin
            srwd <= srwd_nx;
            bp   <= bp_nx;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (take) begin
        if (cmd_op == OP_WEN) begin
          wel <= 1'b1;
        end else if (cmd_op == OP_WDIS) begin
          wel <= 1'b0;
        end else if (is_cyc) begin
          if (ok) begin
            grant <= 1'b1;
            wip   <= 1'b1;
            cnt   <= len;
            if (cmd_op == OP_SWR) begin
              pend_sr <= 1'b1;
              srwd_nx <= cmd_wdata[7];
              bp_nx   <= cmd_wdata[4:2];
            end
          end else begin
            deny <= 1'b1;
          end
        end
      end
    end
  end

  assign status = {srwd, 2'b00, bp, wel, wip};
  assign busy   = wip;

  // R3
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  // R8
  wip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> grant);

  // R8
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  // R10
  lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && locked) |=> (!grant && !deny));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wip && cnt != '0) |=> (!grant && !deny && $stable(status)));

  // R6
  hw_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_SWR && hw_lock) |=> deny);

  // R5
  chip_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_CERS && bp != 3'd0) |=> deny);

endmodule

// File: tb/tb_flash_status_guard.sv
`timescale 1ns/1ps
module tb_flash_status_guard;
  localparam int TW = 3, TP = 5, TS = 7, TB = 9, TC = 11, TU = 20;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1, cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd7;
  logic [23:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic [7:0]  status;
  logic grant, deny, busy;

  int checks = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_status_guard #(.T_WRSR(TW), .T_PP(TP), .T_SE(TS), .T_BE(TB),
                       .T_CE(TC), .T_PUW(TU)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .status(status), .grant(grant), .deny(deny), .busy(busy));

  // behavioural reference
  bit m_srwd, m_wel, m_wip, m_pend, m_psrwd, m_grant, m_deny;
  int m_bp, m_pbp, m_left, m_age;

  function automatic int cyc_len(int op);
    case (op) 2: return TW; 3: return TP; 4: return TS; 5: return TB; default: return TC; endcase
  endfunction

  function automatic bit addr_protected(int bpv, int addr);
    int nprot;
    nprot = (bpv == 0) ? 0 : (bpv >= 5) ? 16 : (1 << (bpv - 1));
    return nprot != 0 && (addr >> 16) >= 16 - nprot;
  endfunction

  always @(posedge clk) begin
    bit lk, allow;
    if (!rst_n) begin
      m_srwd = 0; m_wel = 0; m_wip = 0; m_pend = 0; m_bp = 0; m_age = 0;
      m_grant = 0; m_deny = 0; m_left = 0;
    end else begin
      lk = m_age < TU;
      if (lk) m_age++;
      m_grant = 0; m_deny = 0;
      if (m_wip) begin
        m_left--;
        if (m_left == 0) begin
          m_wip = 0; m_wel = 0;
          if (m_pend) begin m_srwd = m_psrwd; m_bp = m_pbp; m_pend = 0; end
        end
      end else if (cmd_valid && !lk) begin
        if (cmd_op == 0) m_wel = 1;
        else if (cmd_op == 1) m_wel = 0;
        else if (cmd_op != 7) begin
          if (cmd_op == 2) allow = !(m_srwd && !wp_n);
          else if (cmd_op == 6) allow = m_bp == 0;
          else allow = !addr_protected(m_bp, int'(cmd_addr));
          allow = allow && m_wel;
          if (allow) begin
            m_grant = 1; m_wip = 1; m_left = cyc_len(int'(cmd_op));
            if (cmd_op == 2) begin m_pend = 1; m_psrwd = cmd_wdata[7]; m_pbp = int'(cmd_wdata[4:2]); end
          end else m_deny = 1;
        end
      end
    end
  end

  task automatic chk(bit cond, string tag, int act, int exp);
    checks++;
    if (!cond) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(status == {m_srwd, 2'b00, 3'(m_bp), m_wel, m_wip}, "R1 status vs model",
          int'(status), int'({m_srwd, 2'b00, 3'(m_bp), m_wel, m_wip}));
      chk(grant == m_grant && deny == m_deny, "R3 grant/deny vs model",
          int'({grant, deny}), int'({m_grant, m_deny}));
      chk(busy == m_wip, "R8 busy vs model", int'(busy), int'(m_wip));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic issue(int op, int addr, int data);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = 24'(addr); cmd_wdata = 8'(data);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 3'd7;
  endtask

  task automatic resp(bit g, bit d, string tag);
    chk(grant == g && deny == d, tag, int'({grant, deny}), int'({g, d}));
  endtask

  task automatic wait_idle(int exp_len, string tag);
    int n = 0;
    while (busy) begin n++; @(negedge clk); end
    if (exp_len > 0) chk(n == exp_len, tag, n, exp_len);
  endtask

  task automatic set_status(int data);
    issue(0, 0, 0);
    issue(2, 0, data);
    wait_idle(TW, "R8 status write length");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 8'h00, "R1 reset status", int'(status), 0);
    rst_n = 1;
    issue(0, 0, 0);
    resp(0, 0, "R10 lockout no pulse");
    chk(status == 8'h00, "R10 lockout write-enable ignored", int'(status), 0);
    repeat (TU + 2) @(negedge clk);

    issue(3, 24'h000100, 0);
    resp(0, 1, "R3 program without WEL denied");
    issue(0, 0, 0);
    resp(0, 0, "R2 write-enable no pulse");
    chk(status == 8'h02, "R2 WEL set", int'(status), 2);
    issue(1, 0, 0);
    chk(status == 8'h00, "R2 WEL cleared", int'(status), 0);

    issue(0, 0, 0);
    issue(2, 0, 8'hFF);
    resp(1, 0, "R3 status write granted");
    chk(status == 8'h03, "R7 bits unchanged until end", int'(status), 3);
    wait_idle(TW, "R8 status write length");
    chk(status == 8'h9C, "R7 status write result", int'(status), 8'h9C);

    wp_n = 0;
    issue(0, 0, 0);
    issue(2, 0, 8'h00);
    resp(0, 1, "R6 hardware protect denies");
    chk(status == 8'h9E, "R6 status kept", int'(status), 8'h9E);
    wp_n = 1;
    issue(2, 0, 8'h00);
    resp(1, 0, "R6 pin released grants");
    wait_idle(TW, "R8 length");
    chk(status == 8'h00, "R6 cleared", int'(status), 0);

    set_status(8'h63);
    chk(status == 8'h00, "R7 bits 6,5,1,0 ignored", int'(status), 0);

    set_status(8'h04);
    issue(0, 0, 0);
    issue(4, 24'h0F0000, 0);
    resp(0, 1, "R4 bp1 block15 denied");
    chk(status == 8'h06, "R3 deny keeps WEL", int'(status), 6);
    issue(4, 24'h0EFFFF, 0);
    resp(1, 0, "R4 bp1 block14 granted");
    wait_idle(TS, "R8 sector erase length");

    set_status(8'h08);
    issue(0, 0, 0);
    issue(5, 24'h0E1234, 0);
    resp(0, 1, "R4 bp2 block14 denied");
    issue(5, 24'h0D0000, 0);
    resp(1, 0, "R4 bp2 block13 granted");
    wait_idle(TB, "R8 block erase length");

    set_status(8'h0C);
    issue(0, 0, 0);
    issue(3, 24'h0C0000, 0);
    resp(0, 1, "R4 bp3 block12 denied");
    issue(3, 24'h0BFFFF, 0);
    resp(1, 0, "R4 bp3 block11 granted");
    wait_idle(TP, "R8 program length");

    set_status(8'h10);
    issue(0, 0, 0);
    issue(4, 24'h080000, 0);
    resp(0, 1, "R4 bp4 block8 denied");
    issue(6, 0, 0);
    resp(0, 1, "R5 chip erase with bp4 denied");
    issue(4, 24'h07FFFF, 0);
    resp(1, 0, "R4 bp4 block7 granted");
    wait_idle(TS, "R8 length");

    set_status(8'h14);
    issue(0, 0, 0);
    issue(3, 24'h000000, 0);
    resp(0, 1, "R4 bp5 all denied");
    issue(7, 0, 0);
    resp(0, 0, "R11 unused code no pulse");
    chk(status == 8'h16, "R11 status unchanged", int'(status), 8'h16);
    issue(2, 0, 8'h00);
    wait_idle(TW, "R8 length");

    issue(0, 0, 0);
    issue(6, 0, 0);
    resp(1, 0, "R5 chip erase granted");
    issue(1, 0, 0);
    resp(0, 0, "R9 dropped while busy");
    chk(status == 8'h03, "R9 WEL kept while busy", int'(status), 3);
    issue(3, 0, 0);
    resp(0, 0, "R9 program dropped while busy");
    wait_idle(TC - 4, "R8 chip erase remainder");
    chk(status == 8'h00, "R8 WIP and WEL cleared", int'(status), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule